// File: doc/BRIEF.md
# End-of-Interrupt Priority Drop Unit

This block is the write-only completion port of an interrupt controller's per-processor interface. Software finishes handling an interrupt by writing that interrupt's identifier to one memory-mapped word. The block keeps a stack of nested interrupts, each entry holding an identifier and an 8-bit priority. An acknowledge event pushes an entry and marks the interrupt active. An accepted completion write pops the top entry, which is the priority drop. Depending on an end-of-interrupt mode bit chosen by the security state of the writer, the same write also clears the interrupt's active flag.

Each write passes through a filter first. Reserved identifiers are discarded. While the security split is in force, writes that cross security groups are discarded. A write that survives the filter but does not name the top-of-stack entry changes nothing and raises a one-cycle error pulse. An acknowledge that finds the stack full is dropped and also raises the error pulse. When an acknowledge and a write arrive in the same cycle, the acknowledge is applied first.

The stack controller is a three-state machine:
- ST_EMPTY moves to ST_NESTED on a push that is not cancelled by a pop in the same cycle. It moves straight to ST_FULL if the depth is 1.
- ST_NESTED moves to ST_EMPTY when the depth reaches 0, and to ST_FULL when the depth reaches DEPTH.
- ST_FULL moves to ST_NESTED on a pop, or to ST_EMPTY if that pop leaves no entries.

All outputs change at the clock edge that samples the stimulus.

Top module: `eoi_drop_unit`

## Requirements
- R1: Only writes with `wr_en`=1 and `wr_addr`=0x010 are completion writes. Writes to other addresses change nothing. Data bits [31:24] are ignored.
- R2: An acknowledge pushes {identifier, priority} and sets `active_o[id]`. `run_prio_o` shows the top entry's priority, or 0xFF when the stack is empty.
- R3: An accepted write that matches the top entry pops it, so nested interrupts are completed in reverse acknowledge order.
- R4: On a pop, the active flag is cleared when the mode bit of the writer is 0, and kept when it is 1. The writer's mode bit is `eoimode_s` for secure writes and `eoimode_ns` for non-secure writes.
- R5: Writes naming identifiers 1020 to 1023 (data bits [9:0]) are ignored and raise no error.
- R6: With `sec_disable`=0, a secure write to an interrupt whose `irq_group` bit is 1 is ignored.
- R7: With `sec_disable`=0, a non-secure write to an interrupt whose group bit is 0 is ignored when `eoimode_s`=1.
- R8: With `sec_disable`=1, no group filtering applies to either security state. The mode bit still follows the writer's security state.
- R9: Data bits [23:13] are ignored. For identifiers 0 to 15, bits [12:10] (the source processor) must also match the acknowledged value. For all other identifiers these bits are ignored.
- R10: An accepted write that does not match the top entry, or that arrives while the stack is empty, leaves the stack and the flags unchanged and raises `err_o` for exactly one cycle.
- R11: An acknowledge that arrives while 8 entries are held is dropped. Its active flag is not set, and `err_o` pulses.
- R12: When an acknowledge and a completion write arrive in the same cycle, the push is applied first, and the write is then compared against the new top.
- R13: After reset the stack is empty, `run_prio_o`=0xFF, all active flags are 0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data; bits [23:0] carry the identifier |
| wr_secure | input | 1 | 1 for a secure write |
| ack_valid | input | 1 | Acknowledge event |
| ack_id | input | 24 | Acknowledged identifier, including the source processor bits |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| sec_disable | input | 1 | 1 disables the security split |
| eoimode_s | input | 1 | Mode bit for secure writers (1 = drop only) |
| eoimode_ns | input | 1 | Mode bit for non-secure writers (1 = drop only) |
| irq_group | input | 64 | Group bit of each interrupt |
| active_o | output | 64 | Active flag of each interrupt |
| run_prio_o | output | 8 | Running priority |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The assertions assume that the control inputs `sec_disable`, `eoimode_s`, `eoimode_ns` and `irq_group` stay constant across any cycle they judge. They also assume that acknowledged identifiers lie below 64. The stimulus changes the controls only between transactions, while `wr_en` and `ack_valid` are low, and uses only identifiers below 64 apart from the reserved ones.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
    localparam int KEY_W = 13;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [7:0]       prio;
    } stk_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } stk_state_t;

    // Comparison key: source processor bits kept only for identifiers 0..15
    function automatic logic [KEY_W-1:0] norm_key(input logic [23:0] id);
        logic sgi;
        sgi = (id[9:0] < 10'd16);
        return {(sgi ? id[12:10] : 3'b000), id[9:0]};
    endfunction
endpackage

// File: rtl/eoi_filter.sv
module eoi_filter
    import eoi_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               wr_fire,
    input  logic [31:0]        wr_data,
    input  logic               wr_secure,
    input  logic               sec_disable,
    input  logic               eoimode_s,
    input  logic               eoimode_ns,
    input  logic [NUM_IRQ-1:0] irq_group,
    output logic               accept,
    output logic               mode_bit,
    output logic [KEY_W-1:0]   key
);
    localparam int          IRQ_W   = $clog2(NUM_IRQ);
    localparam logic [9:0]  IRQ_LIM = 10'(NUM_IRQ);

    logic [9:0] num;
    logic       grp1;
    logic       reserved;
    logic       blocked;

    always_comb begin
        num      = wr_data[9:0];
        key      = norm_key(wr_data[23:0]);
        reserved = (num >= 10'd1020);
        grp1     = (num < IRQ_LIM) ? irq_group[num[IRQ_W-1:0]] : 1'b0;
        blocked  = 1'b0;
        if (!sec_disable) begin
            if (wr_secure && grp1)                     blocked = 1'b1;
            if (!wr_secure && !grp1 && eoimode_s)      blocked = 1'b1;
        end
        accept   = wr_fire && !reserved && !blocked;
        mode_bit = wr_secure ? eoimode_s : eoimode_ns;
    end
endmodule

// File: rtl/eoi_prio_stack.sv
module eoi_prio_stack
    import eoi_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [KEY_W-1:0] push_key,
    input  logic [7:0]       push_prio,
    input  logic             eoi_req,
    input  logic [KEY_W-1:0] eoi_key,
    output logic             push_ok,
    output logic             pop,
    output logic             mismatch,
    output logic             overflow,
    output logic [7:0]       run_prio
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    stk_state_t       state_q, state_d;
    stk_entry_t       stk_q [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
    stk_entry_t       top_mid;

    // Push first, then evaluate the write against the resulting top
    always_comb begin
        push_ok  = push_req && (state_q != ST_FULL);
        overflow = push_req && (state_q == ST_FULL);
        cnt_mid  = cnt_q + CNT_W'(push_ok);
        if (push_ok)
            top_mid = '{key: push_key, prio: push_prio};
        else if (cnt_q != '0)
            top_mid = stk_q[IDX_W'(cnt_q - 1'b1)];
        else
            top_mid = '{key: '0, prio: 8'hFF};
        pop      = eoi_req && (cnt_mid != '0) && (top_mid.key == eoi_key);
        mismatch = eoi_req && !pop;
        cnt_d    = cnt_mid - CNT_W'(pop);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (cnt_d != '0)
                           state_d = (cnt_d == CNT_MAX) ? ST_FULL : ST_NESTED;
            ST_NESTED: if (cnt_d == '0)            state_d = ST_EMPTY;
                       else if (cnt_d == CNT_MAX)  state_d = ST_FULL;
            ST_FULL:   if (pop)
                           state_d = (cnt_d == '0) ? ST_EMPTY : ST_NESTED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            stk_q[IDX_W'(cnt_q)] <= '{key: push_key, prio: push_prio};
    end

    always_comb begin
        if (state_q == ST_EMPTY)
            run_prio = 8'hFF;
        else
            run_prio = stk_q[IDX_W'(cnt_q - 1'b1)].prio;
    end

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && push_req && !eoi_req) |=> (cnt_q == CNT_MAX));

    // R2
    empty_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt_q == CNT_W'(1) && !push_req) |=> (run_prio == 8'hFF));

    // R3
    pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_req) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/eoi_drop_unit.sv
module eoi_drop_unit
    import eoi_pkg::*;
#(
    parameter int          NUM_IRQ    = 64,
    parameter int          DEPTH      = 8,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] EOI_OFFSET = 12'h010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               wr_secure,
    input  logic               ack_valid,
    input  logic [23:0]        ack_id,
    input  logic [7:0]         ack_prio,
    input  logic               sec_disable,
    input  logic               eoimode_s,
    input  logic               eoimode_ns,
    input  logic [NUM_IRQ-1:0] irq_group,
    output logic [NUM_IRQ-1:0] active_o,
    output logic [7:0]         run_prio_o,
    output logic               err_o
);
    localparam int         IRQ_W   = $clog2(NUM_IRQ);
    localparam logic [9:0] IRQ_LIM = 10'(NUM_IRQ);

    logic             wr_fire, accept, mode_bit;
    logic [KEY_W-1:0] eoi_key;
    logic             push_ok, pop, mismatch, overflow;

    assign wr_fire = wr_en && (wr_addr == ADDR_W'(EOI_OFFSET));

    eoi_filter #(.NUM_IRQ(NUM_IRQ)) u_filter (
        .wr_fire    (wr_fire),
        .wr_data    (wr_data),
        .wr_secure  (wr_secure),
        .sec_disable(sec_disable),
        .eoimode_s  (eoimode_s),
        .eoimode_ns (eoimode_ns),
        .irq_group  (irq_group),
        .accept     (accept),
        .mode_bit   (mode_bit),
        .key        (eoi_key)
    );

    eoi_prio_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (ack_valid),
        .push_key (norm_key(ack_id)),
        .push_prio(ack_prio),
        .eoi_req  (accept),
        .eoi_key  (eoi_key),
        .push_ok  (push_ok),
        .pop      (pop),
        .mismatch (mismatch),
        .overflow (overflow),
        .run_prio (run_prio_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o <= '0;
            err_o    <= 1'b0;
        end else begin
            err_o <= mismatch || overflow;
            if (push_ok && ack_id[9:0] < IRQ_LIM)
                active_o[ack_id[IRQ_W-1:0]] <= 1'b1;
            if (pop && !mode_bit && wr_data[9:0] < IRQ_LIM)
                active_o[wr_data[IRQ_W-1:0]] <= 1'b0;
        end
    end

    // R5
    reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_data[9:0] >= 10'd1020 && !ack_valid)
        |=> ($stable(active_o) && $stable(run_prio_o) && !err_o));

    // R6
    grp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_secure && !sec_disable && !ack_valid
         && wr_data[9:0] < IRQ_LIM && irq_group[wr_data[IRQ_W-1:0]])
        |=> ($stable(run_prio_o) && $stable(active_o)));

    // R4
    deactivate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !mode_bit && wr_data[9:0] < IRQ_LIM)
        |=> !active_o[$past(wr_data[IRQ_W-1:0])]);

    // R11
    overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> err_o);
endmodule

// File: tb/eoi_drop_unit_tb.sv
module eoi_drop_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = 12'h010;
    logic [31:0] wr_data = '0;
    logic        wr_secure = 1'b0;
    logic        ack_valid = 1'b0;
    logic [23:0] ack_id = '0;
    logic [7:0]  ack_prio = '0;
    logic        sec_disable = 1'b0;
    logic        eoimode_s = 1'b0;
    logic        eoimode_ns = 1'b0;
    logic [63:0] irq_group = {32'hFFFF_FFFF, 32'h0};
    logic [63:0] active_o;
    logic [7:0]  run_prio_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    eoi_drop_unit u_dut (.*);

    typedef struct packed {
        logic        is_ack;
        logic        sec;
        logic [31:0] data;
        logic [7:0]  prio;
        logic [7:0]  exp_rp;
        logic        exp_err;
        logic [5:0]  idx;
        logic        exp_act;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h0000_0005, 8'h80, 8'h80, 1'b0, 6'd5,  1'b1}, // R2
        '{1'b1, 1'b1, 32'h0000_0009, 8'h40, 8'h40, 1'b0, 6'd9,  1'b1}, // R2
        '{1'b0, 1'b1, 32'h0000_0005, 8'h00, 8'h40, 1'b1, 6'd5,  1'b1}, // R10
        '{1'b0, 1'b1, 32'hAB00_0009, 8'h00, 8'h80, 1'b0, 6'd9,  1'b0}, // R1 R3
        '{1'b0, 1'b1, 32'h0000_03FD, 8'h00, 8'h80, 1'b0, 6'd5,  1'b1}, // R5
        '{1'b0, 1'b1, 32'h00FF_E005, 8'h00, 8'hFF, 1'b0, 6'd5,  1'b0}, // R9
        '{1'b0, 1'b1, 32'h0000_0005, 8'h00, 8'hFF, 1'b1, 6'd5,  1'b0}, // R10
        '{1'b1, 1'b1, 32'h0000_0C02, 8'h20, 8'h20, 1'b0, 6'd2,  1'b1}, // R9
        '{1'b0, 1'b1, 32'h0000_0802, 8'h00, 8'h20, 1'b1, 6'd2,  1'b1}, // R9
        '{1'b0, 1'b1, 32'h0000_0C02, 8'h00, 8'hFF, 1'b0, 6'd2,  1'b0}, // R9
        '{1'b1, 1'b1, 32'h0000_0028, 8'h30, 8'h30, 1'b0, 6'd40, 1'b1}, // R2
        '{1'b0, 1'b1, 32'h0000_0028, 8'h00, 8'h30, 1'b0, 6'd40, 1'b1}, // R6
        '{1'b0, 1'b0, 32'h0000_0028, 8'h00, 8'hFF, 1'b0, 6'd40, 1'b0}  // R4
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive for one edge, then sample 1 ns after it
    task automatic step(input logic a, input logic [23:0] aid, input logic [7:0] ap,
                        input logic w, input logic s, input logic [31:0] d,
                        input logic [11:0] adr);
        ack_valid = a; ack_id = aid; ack_prio = ap;
        wr_en = w; wr_secure = s; wr_data = d; wr_addr = adr;
        @(posedge clk);
        #1;
        ack_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic ack(input logic [23:0] aid, input logic [7:0] ap);
        step(1'b1, aid, ap, 1'b0, 1'b0, 32'h0, 12'h010);
    endtask

    task automatic eoi(input logic s, input logic [31:0] d);
        step(1'b0, 24'h0, 8'h0, 1'b1, s, d, 12'h010);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R13 run_prio", run_prio_o, 8'hFF);
        check("R13 active",   active_o,   64'h0);
        check("R13 err",      err_o,      1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_ack) ack(VECS[i].data[23:0], VECS[i].prio);
            else                eoi(VECS[i].sec, VECS[i].data);
            check($sformatf("R3 vec%0d run_prio", i), run_prio_o, VECS[i].exp_rp);
            check($sformatf("R10 vec%0d err", i), err_o, VECS[i].exp_err);
            check($sformatf("R2 vec%0d active", i), active_o[VECS[i].idx], VECS[i].exp_act);
        end

        // R4: secure mode bit 1 drops priority only
        eoimode_s = 1'b1;
        ack(24'd7, 8'h50);
        eoi(1'b1, 32'd7);
        check("R4 drop run_prio", run_prio_o, 8'hFF);
        check("R4 flag kept", active_o[7], 1'b1);

        // R7: non-secure write to group 0 ignored while eoimode_s=1
        ack(24'd8, 8'h60);
        eoi(1'b0, 32'd8);
        check("R7 ignored run_prio", run_prio_o, 8'h60);
        check("R7 no err", err_o, 1'b0);
        eoi(1'b1, 32'd8);
        check("R7 secure pop", run_prio_o, 8'hFF);
        eoimode_s = 1'b0;

        // R8: security split disabled, no group filter, writer's mode bit
        sec_disable = 1'b1;
        ack(24'd41, 8'h22);
        eoi(1'b1, 32'd41);
        check("R8 secure to group1 run_prio", run_prio_o, 8'hFF);
        check("R8 secure to group1 flag", active_o[41], 1'b0);
        eoimode_ns = 1'b1;
        ack(24'd11, 8'h33);
        eoi(1'b0, 32'd11);
        check("R8 ns drop run_prio", run_prio_o, 8'hFF);
        check("R8 ns mode flag kept", active_o[11], 1'b1);
        eoimode_ns = 1'b0;
        sec_disable = 1'b0;

        // R1: wrong offset ignored
        ack(24'd12, 8'h44);
        step(1'b0, 24'h0, 8'h0, 1'b1, 1'b1, 32'd12, 12'h014);
        check("R1 wrong addr run_prio", run_prio_o, 8'h44);
        check("R1 wrong addr flag", active_o[12], 1'b1);
        eoi(1'b1, 32'd12);
        check("R1 right addr flag", active_o[12], 1'b0);

        // R11: fill the stack, overflow, then unwind in reverse (R3)
        for (int k = 0; k < 8; k++) ack(24'(16 + k), 8'(8'h70 - k));
        check("R11 full run_prio", run_prio_o, 8'h69);
        ack(24'd24, 8'h05);
        check("R11 overflow err", err_o, 1'b1);
        check("R11 overflow run_prio", run_prio_o, 8'h69);
        check("R11 dropped flag", active_o[24], 1'b0);
        @(posedge clk); #1;
        check("R10 err one cycle", err_o, 1'b0);
        for (int k = 7; k >= 0; k--) begin
            eoi(1'b1, 32'(16 + k));
            check($sformatf("R3 unwind %0d", k), run_prio_o,
                  (k == 0) ? 8'hFF : 8'(8'h70 - k + 1));
        end
        check("R3 unwind flags", active_o[23:16], 8'h00);

        // R12: same-cycle acknowledge and write, push first
        step(1'b1, 24'd30, 8'h10, 1'b1, 1'b1, 32'd30, 12'h010);
        check("R12 run_prio", run_prio_o, 8'hFF);
        check("R12 flag", active_o[30], 1'b0);
        check("R12 no err", err_o, 1'b0);

        finish_run();
    end
endmodule